// File: doc/BRIEF.md
# Page Write Collector and Timed Commit Engine

This block sits between the serial protocol controller of a byte-addressed nonvolatile memory and its storage array. While a write transaction is open it takes the data bytes the controller has received and places them in a 32-entry page buffer. A per-entry valid mask records which buffer entries hold a byte. The entry index starts at the low address bits of the loaded starting address and steps by one per byte, wrapping inside the page. The page number (the upper address bits) does not change during the transaction.

When the controller reports the STOP that ends the transaction, the engine checks three things: at least one byte was buffered, the write-protect input stayed low on every cycle of the transaction, and the supply-low flag is clear. If all three hold, it raises `busy` for a fixed number of clock cycles and drains the buffered entries into the array through a single-byte write port. If any one fails, the buffer is discarded and `busy` stays low. While `busy` is high, and for one quiet cycle after it falls, every transaction input is ignored.

Top module: `pgw_engine`

## Requirements
- R1: After reset, `busy` and `ram_we` are low, and the valid mask is empty, so a STOP with no transaction commits nothing.
- R2: A byte received as the k-th byte after `addr_load` goes to array address `{addr_in[ADDR_W-1:5], (addr_in[4:0] + k) mod 32}`. The upper bits of `ram_addr` are the same for every write of one commit.
- R3: When more than 32 bytes arrive, the index wraps to the start of the same page, and a later byte replaces the earlier byte at the same entry. Each entry is written once per commit and carries the latest byte.
- R4: Only entries that received a byte are written. A commit issues exactly one `ram_we` pulse per such entry, in ascending order of entry index (0 to 31), on consecutive cycles where the entries are adjacent.
- R5: A granted STOP raises `busy` in the next cycle. `busy` stays high for exactly `WCYC` cycles, then stays low for at least one cycle before a new STOP can be taken.
- R6: `ram_we` is high only while `busy` is high.
- R7: While `busy` is high, `txn_start`, `addr_load`, `byte_vld` and `stop_commit` have no effect. The commit in progress keeps its bytes and its length, and those bytes do not remain in the buffer afterwards.
- R8: If `wp` is high on any cycle from the `txn_start` cycle through the STOP cycle, the STOP commits nothing and `busy` stays low.
- R9: If `vlow` is high in the STOP cycle, the STOP commits nothing and `busy` stays low.
- R10: A STOP when no data byte was buffered (for example after an address-only transaction) commits nothing and `busy` stays low.
- R11: The valid mask is emptied by `txn_start`, by a refused STOP and at the end of each commit. A new transaction writes only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | Pulse: a write transaction opens; empties the mask and restarts WP sampling |
| addr_load | input | 1 | Pulse: take `addr_in` as the starting array address |
| addr_in | input | ADDR_W | Starting array address (page number and entry index) |
| byte_vld | input | 1 | Pulse: one data byte is present on `byte_data` |
| byte_data | input | DATA_W | Received data byte |
| stop_commit | input | 1 | Pulse: the transaction ended with STOP |
| wp | input | 1 | Write-protect level, high means protected |
| vlow | input | 1 | Supply-low inhibit flag |
| busy | output | 1 | Timed write cycle in progress |
| ram_we | output | 1 | Array write strobe |
| ram_addr | output | ADDR_W | Array write address |
| ram_wdata | output | DATA_W | Array write data |

## Verification
A wrong entry index or page register shows up on `ram_addr` during the next commit. A stale or wrongly cleared valid mask shows up as an extra or missing write pulse. Both are seen within the first 32 cycles after `busy` rises. A fault in the protect latch or the timer shows up at the STOP itself: `busy` rises when it must not, or stays high for a different number of cycles than `WCYC`. Gating faults during the busy window appear either as a changed write list for the commit in progress, or as a spurious commit on the next bare STOP.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [1:0] {
    ST_OPEN = 2'd0,
    ST_BUSY = 2'd1,
    ST_GAP  = 2'd2
  } pgw_state_e;

  // A STOP may start a write cycle only with data present,
  // protection never seen and supply good.
  function automatic logic commit_allowed(input logic any_data,
                                          input logic wp_seen,
                                          input logic wp_now,
                                          input logic low_supply);
    return any_data && !wp_seen && !wp_now && !low_supply;
  endfunction

endpackage

// File: rtl/pgw_collect.sv
module pgw_collect #(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - IDX_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         accept,
  input  logic                         txn_start,
  input  logic                         addr_load,
  input  logic [ADDR_W-1:0]            addr_in,
  input  logic                         byte_vld,
  input  logic [DATA_W-1:0]            byte_data,
  input  logic                         stop_seen,
  input  logic                         mask_clr,
  input  logic                         wp,
  output logic [PG_W-1:0]              page_o,
  output logic [PAGE_BYTES-1:0]        mask_o,
  output logic [PAGE_BYTES*DATA_W-1:0] data_o,
  output logic                         wp_seen_o,
  output logic                         byte_take_o
);

  function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] i);
    return i + 1'b1;
  endfunction

  logic              txn_open;
  logic [IDX_W-1:0]  idx_q;
  logic              clr_all;
  logic              take;
  logic              load;

  assign clr_all     = mask_clr || (accept && txn_start);
  assign take        = accept && txn_open && byte_vld && !txn_start;
  assign load        = accept && txn_open && addr_load && !txn_start;
  assign byte_take_o = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txn_open <= 1'b0;
    end else if (accept && txn_start) begin
      txn_open <= 1'b1;
    end else if (accept && stop_seen) begin
      txn_open <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_seen_o <= 1'b0;
    end else if (accept && txn_start) begin
      wp_seen_o <= wp;
    end else if (accept && txn_open && wp) begin
      wp_seen_o <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      page_o <= '0;
    end else if (load) begin
      idx_q  <= addr_in[IDX_W-1:0];
      page_o <= addr_in[ADDR_W-1:IDX_W];
    end else if (take) begin
      idx_q  <= next_idx(idx_q);
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
    logic hit;
    assign hit = take && (idx_q == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_o[g] <= 1'b0;
      end else if (clr_all) begin
        mask_o[g] <= 1'b0;
      end else if (hit) begin
        mask_o[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_o[g*DATA_W +: DATA_W] <= '0;
      end else if (hit) begin
        data_o[g*DATA_W +: DATA_W] <= byte_data;
      end
    end
  end

endmodule

// File: rtl/pgw_timer.sv
module pgw_timer #(
  parameter int WCYC  = 625000,
  localparam int CNT_W = $clog2(WCYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             active,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  function automatic logic at_end(input logic [CNT_W-1:0] c);
    return c == CNT_W'(WCYC - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
    end else if (start) begin
      cnt_o <= '0;
    end else if (active) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  assign expire_o = active && at_end(cnt_o);

endmodule

// File: rtl/pgw_drain.sv
module pgw_drain #(
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int CNT_W      = 20,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic                         active,
  input  logic [CNT_W-1:0]             cnt_i,
  input  logic [PAGE_BYTES-1:0]        mask_i,
  input  logic [PAGE_BYTES*DATA_W-1:0] data_i,
  output logic                         we_o,
  output logic [IDX_W-1:0]             idx_o,
  output logic [DATA_W-1:0]            byte_o
);

  function automatic logic in_window(input logic [CNT_W-1:0] c);
    return 32'(c) < PAGE_BYTES;
  endfunction

  assign idx_o  = cnt_i[IDX_W-1:0];
  assign byte_o = data_i[idx_o*DATA_W +: DATA_W];
  assign we_o   = active && in_window(cnt_i) && mask_i[idx_o];

endmodule

// File: rtl/pgw_engine.sv
module pgw_engine
  import pgw_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int WCYC       = 625000,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = ADDR_W - IDX_W,
  localparam int CNT_W     = $clog2(WCYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_commit,
  input  logic              wp,
  input  logic              vlow,
  output logic              busy,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);

  pgw_state_e                  state_q;
  logic                        accept;
  logic [PG_W-1:0]             page;
  logic [PAGE_BYTES-1:0]       mask;
  logic [PAGE_BYTES*DATA_W-1:0] buf_data;
  logic                        wp_seen;
  logic [CNT_W-1:0]            cnt;
  logic [IDX_W-1:0]            drain_idx;
  logic                        mask_clr;

  // Named events for the checker
  logic ev_stop;
  logic ev_stop_go;
  logic ev_stop_drop;
  logic ev_expire;
  logic ev_byte_take;

  assign accept       = (state_q == ST_OPEN);
  assign ev_stop      = accept && stop_commit;
  assign ev_stop_go   = ev_stop && commit_allowed(|mask, wp_seen, wp, vlow);
  assign ev_stop_drop = ev_stop && !ev_stop_go;
  assign mask_clr     = ev_stop_drop || (state_q == ST_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPEN;
    end else begin
      unique case (state_q)
        ST_OPEN: if (ev_stop_go) state_q <= ST_BUSY;
        ST_BUSY: if (ev_expire)  state_q <= ST_GAP;
        ST_GAP:                  state_q <= ST_OPEN;
        default:                 state_q <= ST_OPEN;
      endcase
    end
  end

  assign busy = (state_q == ST_BUSY);

  pgw_collect #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_collect (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .txn_start   (txn_start),
    .addr_load   (addr_load),
    .addr_in     (addr_in),
    .byte_vld    (byte_vld),
    .byte_data   (byte_data),
    .stop_seen   (stop_commit),
    .mask_clr    (mask_clr),
    .wp          (wp),
    .page_o      (page),
    .mask_o      (mask),
    .data_o      (buf_data),
    .wp_seen_o   (wp_seen),
    .byte_take_o (ev_byte_take)
  );

  pgw_timer #(
    .WCYC (WCYC)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (ev_stop_go),
    .active   (busy),
    .cnt_o    (cnt),
    .expire_o (ev_expire)
  );

  pgw_drain #(
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE_BYTES),
    .CNT_W      (CNT_W)
  ) u_drain (
    .active (busy),
    .cnt_i  (cnt),
    .mask_i (mask),
    .data_i (buf_data),
    .we_o   (ram_we),
    .idx_o  (drain_idx),
    .byte_o (ram_wdata)
  );

  assign ram_addr = {page, drain_idx};

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 5,
  parameter int WCYC   = 625000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              ev_stop_go,
  input logic              ev_stop_drop,
  input logic              ev_expire,
  input logic              ev_byte_take
);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> busy); // R6

  AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_go |=> busy); // R5

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < 32'(WCYC))); // R5

  AST_GAP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ev_expire |=> (!busy && !ram_we)); // R5

  AST_DROP_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_drop |=> !busy); // R8

  AST_NO_TAKE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ev_byte_take); // R7

  AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |->
      (ram_addr[ADDR_W-1:IDX_W] == $past(ram_addr[ADDR_W-1:IDX_W]))); // R2

  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && $past(ram_we)) |->
      (ram_addr[IDX_W-1:0] == $past(ram_addr[IDX_W-1:0]) + 1'b1)); // R4

endmodule

bind pgw_engine pgw_checker #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W),
  .WCYC   (WCYC)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .ram_we       (ram_we),
  .ram_addr     (ram_addr),
  .ev_stop_go   (ev_stop_go),
  .ev_stop_drop (ev_stop_drop),
  .ev_expire    (ev_expire),
  .ev_byte_take (ev_byte_take)
);

// File: tb/pgw_engine_bench.sv
module pgw_engine_bench;

  localparam int ADDR_W = 13;
  localparam int DATA_W = 8;
  localparam int PAGE   = 32;
  localparam int WCYC   = 40;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              txn_start = 1'b0;
  logic              addr_load = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic              byte_vld = 1'b0;
  logic [DATA_W-1:0] byte_data = '0;
  logic              stop_commit = 1'b0;
  logic              wp = 1'b0;
  logic              vlow = 1'b0;
  logic              busy;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata;

  always #4 clk = ~clk;

  pgw_engine #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PAGE_BYTES (PAGE),
    .WCYC       (WCYC)
  ) u_pgw_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .txn_start   (txn_start),
    .addr_load   (addr_load),
    .addr_in     (addr_in),
    .byte_vld    (byte_vld),
    .byte_data   (byte_data),
    .stop_commit (stop_commit),
    .wp          (wp),
    .vlow        (vlow),
    .busy        (busy),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .ram_wdata   (ram_wdata)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Observation log, sampled on falling edges
  int          busy_len;
  int          log_n;
  int          r6_bad;
  logic [ADDR_W-1:0] log_addr [0:63];
  logic [DATA_W-1:0] log_data [0:63];

  // Requirement model of the page buffer
  int          m_page;
  int          m_idx;
  logic [7:0]  m_data  [0:PAGE-1];
  bit          m_valid [0:PAGE-1];

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_len++;
      if (ram_we) begin
        if (!busy) r6_bad++;
        if (log_n < 64) begin
          log_addr[log_n] = ram_addr;
          log_data[log_n] = ram_wdata;
        end
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic clear_log();
    busy_len = 0;
    log_n    = 0;
    r6_bad   = 0;
  endtask

  task automatic model_clear();
    for (int j = 0; j < PAGE; j++) m_valid[j] = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); txn_start = 1'b1;
    @(negedge clk); txn_start = 1'b0;
    model_clear();
  endtask

  task automatic do_addr(input int a);
    @(negedge clk); addr_load = 1'b1; addr_in = ADDR_W'(a);
    @(negedge clk); addr_load = 1'b0;
    m_page = a / PAGE;
    m_idx  = a % PAGE;
  endtask

  task automatic do_byte(input int d);
    @(negedge clk); byte_vld = 1'b1; byte_data = DATA_W'(d);
    @(negedge clk); byte_vld = 1'b0;
    m_data[m_idx]  = 8'(d);
    m_valid[m_idx] = 1'b1;
    m_idx = (m_idx + 1) % PAGE;
  endtask

  task automatic pulse_stop();
    @(negedge clk); stop_commit = 1'b1;
    @(negedge clk); stop_commit = 1'b0;
  endtask

  // Compare the observed commit against the model
  task automatic check_commit(input string req, input bit exp_go);
    int exp_n = 0;
    int errs  = 0;
    int k     = 0;
    for (int j = 0; j < PAGE; j++) if (m_valid[j]) exp_n++;
    if (!exp_go) exp_n = 0;
    chk(busy_len == (exp_go ? WCYC : 0), req, "busy cycles", busy_len,
        exp_go ? WCYC : 0);
    chk(log_n == exp_n, req, "write count", log_n, exp_n);
    if (exp_go) begin
      for (int j = 0; j < PAGE; j++) begin
        if (m_valid[j]) begin
          if (k < log_n && k < 64) begin
            if (int'(log_addr[k]) != m_page * PAGE + j) errs++;
            if (log_data[k] != m_data[j]) errs++;
          end
          k++;
        end
      end
      chk(errs == 0, req, "address/data mismatches", errs, 0);
    end
    chk(r6_bad == 0, "R6", "writes outside busy", r6_bad, 0);
    model_clear();
  endtask

  task automatic stop_and_check(input string req, input bit exp_go);
    clear_log();
    pulse_stop();
    repeat (WCYC + 4) @(negedge clk);
    check_commit(req, exp_go);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(ram_we == 1'b0, "R1", "ram_we after reset", ram_we, 0);
    stop_and_check("R1", 1'b0);
  endtask

  task automatic t_single();
    do_start();
    do_addr(13'h1A5);
    do_byte(8'h11); do_byte(8'h22); do_byte(8'h33);
    stop_and_check("R2", 1'b1);
  endtask

  task automatic t_busy_edge();
    int first_busy;
    do_start();
    do_addr(13'h040);
    do_byte(8'h5A);
    clear_log();
    @(negedge clk); stop_commit = 1'b1;
    @(negedge clk); stop_commit = 1'b0;
    first_busy = busy;
    chk(first_busy == 1, "R5", "busy one cycle after stop", first_busy, 1);
    repeat (WCYC + 3) @(negedge clk);
    check_commit("R5", 1'b1);
  endtask

  task automatic t_wrap();
    do_start();
    do_addr(13'h3FE);
    for (int k = 0; k < 34; k++) do_byte(8'h40 + k);
    stop_and_check("R3", 1'b1);
  endtask

  task automatic t_sparse();
    do_start();
    do_addr(13'h0DE);
    do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
    stop_and_check("R4", 1'b1);
  endtask

  task automatic t_ignore();
    do_start();
    do_addr(13'h120);
    do_byte(8'hC0); do_byte(8'hC1);
    clear_log();
    pulse_stop();
    repeat (3) @(negedge clk);
    @(negedge clk); txn_start = 1'b1;
    @(negedge clk); txn_start = 1'b0; addr_load = 1'b1; addr_in = 13'h155;
    @(negedge clk); addr_load = 1'b0; byte_vld = 1'b1; byte_data = 8'hEE;
    @(negedge clk); byte_vld = 1'b0; stop_commit = 1'b1;
    @(negedge clk); stop_commit = 1'b0;
    repeat (WCYC) @(negedge clk);
    check_commit("R7", 1'b1);
    // Anything taken during busy would now be committed by a bare STOP
    stop_and_check("R7", 1'b0);
  endtask

  task automatic t_wp();
    do_start();
    do_addr(13'h200);
    do_byte(8'h01);
    @(negedge clk); wp = 1'b1;
    @(negedge clk); wp = 1'b0;
    do_byte(8'h02);
    stop_and_check("R8", 1'b0);
    do_start();
    do_addr(13'h200);
    do_byte(8'h03);
    @(negedge clk); wp = 1'b1;
    pulse_stop_wp_check();
  endtask

  task automatic pulse_stop_wp_check();
    stop_and_check("R8", 1'b0);
    wp = 1'b0;
  endtask

  task automatic t_vlow();
    do_start();
    do_addr(13'h300);
    do_byte(8'h77);
    vlow = 1'b1;
    stop_and_check("R9", 1'b0);
    vlow = 1'b0;
  endtask

  task automatic t_empty();
    do_start();
    do_addr(13'h0A0);
    stop_and_check("R10", 1'b0);
  endtask

  task automatic t_mask_clear();
    do_start();
    do_addr(13'h400);
    do_byte(8'h10); do_byte(8'h11); do_byte(8'h12); do_byte(8'h13);
    stop_and_check("R11", 1'b1);
    do_start();
    do_addr(13'h40A);
    do_byte(8'h99);
    stop_and_check("R11", 1'b1);
    // Restart without STOP drops the earlier bytes
    do_start();
    do_addr(13'h500);
    do_byte(8'h21); do_byte(8'h22);
    do_start();
    do_addr(13'h510);
    do_byte(8'h31);
    stop_and_check("R11", 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    clear_log();
    model_clear();
    m_page = 0;
    m_idx  = 0;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_busy_edge();
    t_wrap();
    t_sparse();
    t_ignore();
    t_wp();
    t_vlow();
    t_empty();
    t_mask_clear();
    repeat (4) @(negedge clk);
    report();
  end

endmodule